// File: doc/BRIEF.md
# First-Byte-Swap 512b/513b Transcoder

This block takes eight 66-bit line-code blocks in one cycle and packs them into one 513-bit transcoded word. Each input block has a 2-bit sync header and a 64-bit payload. The output word has three parts: a single header bit, a 64-bit field that holds the eight first bytes, and a 448-bit field that holds the other seven bytes of every payload.

Only the first byte of each payload ever moves. The seven trailing bytes of lane i always go to a slot that depends on i alone, so the wide part of the datapath has no multiplexers. When a word holds control blocks, their first bytes go to the front of the first-byte field in a compact form. The first bytes of the data blocks follow them. A receiver can therefore classify every block from the first 65 bits, before the rest of the word arrives.

A sync header that is neither the data code nor the control code raises an error flag for that word. The result is registered, so it appears one cycle after the input is accepted.

Top module: `tc513_transcoder`

## Requirements
- R1: Lane i of the input is `in_blocks[66*i +: 66]`. Bits [1:0] of a lane are its sync header and bits [65:2] are its payload. The first byte of the payload is bits [9:2].
- R2: `out_valid` rises one clock after `in_valid` is sampled high and is low one clock after `in_valid` is sampled low. While `in_valid` is low, `out_word` keeps its value.
- R3: Sync header 2'b01 marks a data lane and 2'b10 marks a control lane. `out_word[0]` is 0 when the word has no control lane and 1 when it has at least one.
- R4: The first-byte field is `out_word[64:1]`, and slot k of that field is `out_word[1+8*k +: 8]`. Slot 0 is sent first, and all slots are sent before bit 65 or any higher bit.
- R5: When no lane carries a control header, slot k holds the unchanged first byte of lane k.
- R6: When at least one control lane is present, the slots hold first the rewritten bytes of the control lanes in ascending lane order, then the unchanged first bytes of the remaining lanes in ascending lane order.
- R7: A rewritten control byte holds the lane index in bits [2:0], a last-control flag in bit 3, and bits [7:4] of the original first byte (the block-type code) in bits [7:4].
- R8: The last-control flag is 1 only in the byte of the highest-numbered control lane. Exactly one rewritten byte carries it when any control lane is present.
- R9: Payload bits [63:8] of lane i (input bits [65:10] of that lane) appear unchanged at `out_word[65+56*i +: 56]`.
- R10: A sync header of 2'b00 or 2'b11 on any lane sets `out_err` in the same cycle as `out_valid` for that word. Such a lane is packed as a data lane. `out_err` is low whenever `out_valid` is low.
- R11: While `rst` is high, `out_valid` and `out_err` are 0 one clock later and `out_word` is cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | The eight input lanes carry a word |
| in_blocks | input | 528 | Eight 66-bit blocks, lane 0 in the low bits |
| out_valid | output | 1 | The transcoded word is present |
| out_word | output | 513 | Transcoded word, bit 0 sent first |
| out_err | output | 1 | The word contained an invalid sync header |

## Verification
Header error detection and control-byte reordering can act on the same word. A lane with a bad header is counted as a data lane while its neighbours are compacted as control lanes. The bench provokes this with directed words that mix 2'b00 or 2'b11 headers with control lanes in high and low positions, and with random words in which each lane draws among all four header codes. For each such word it checks the error flag, the header bit and the exact order of the slots against a reference model, all on the same output word.

// File: rtl/tc513_pkg.sv
package tc513_pkg;
  localparam int NUM_LANES = 8;
  localparam int BLK_W     = 66;
  localparam int PAY_W     = 64;
  localparam int BYTE_W    = 8;
  localparam int IDX_W     = $clog2(NUM_LANES);
  localparam int CNT_W     = IDX_W + 1;
  localparam int REST_W    = PAY_W - BYTE_W;
  localparam int FB_W      = NUM_LANES * BYTE_W;
  localparam int OUT_W     = 1 + NUM_LANES * PAY_W;
  localparam int IN_W      = NUM_LANES * BLK_W;
  localparam logic [1:0] SYNC_DATA = 2'b01;
  localparam logic [1:0] SYNC_CTRL = 2'b10;
endpackage

// File: rtl/tc513_lane_classify.sv
module tc513_lane_classify
  import tc513_pkg::*;
#(
  parameter int LANE = 0
) (
  input  logic [BLK_W-1:0]  blk,
  input  logic              ctl_above,
  output logic              is_ctl,
  output logic              bad_hdr,
  output logic [BYTE_W-1:0] lead_byte
);
  logic [1:0]        hdr;
  logic [BYTE_W-1:0] first;

  assign hdr     = blk[1:0];
  assign first   = blk[2 +: BYTE_W];
  assign is_ctl  = (hdr == SYNC_CTRL);
  assign bad_hdr = (hdr != SYNC_CTRL) && (hdr != SYNC_DATA);

  always_comb begin
    if (is_ctl) begin
      lead_byte        = '0;
      lead_byte[2:0]   = 3'(LANE);
      lead_byte[3]     = ~ctl_above;
      lead_byte[7:4]   = first[7:4];
    end else begin
      lead_byte = first;
    end
  end
endmodule

// File: rtl/tc513_byte_router.sv
module tc513_byte_router
  import tc513_pkg::*;
(
  input  logic [NUM_LANES-1:0] is_ctl,
  input  logic [FB_W-1:0]      bytes_in,
  output logic [FB_W-1:0]      slots_out
);
  logic [CNT_W-1:0] n_ctl;
  logic [CNT_W-1:0] ctl_seen;
  logic [CNT_W-1:0] dat_seen;
  logic [CNT_W-1:0] dest [NUM_LANES];

  always_comb begin
    n_ctl = '0;
    for (int i = 0; i < NUM_LANES; i++) n_ctl = n_ctl + CNT_W'(is_ctl[i]);
    ctl_seen = '0;
    dat_seen = '0;
    for (int i = 0; i < NUM_LANES; i++) begin
      if (is_ctl[i]) begin
        dest[i]  = ctl_seen;
        ctl_seen = ctl_seen + 1'b1;
      end else begin
        dest[i]  = n_ctl + dat_seen;
        dat_seen = dat_seen + 1'b1;
      end
    end
  end

  always_comb begin
    slots_out = '0;
    for (int k = 0; k < NUM_LANES; k++) begin
      for (int i = 0; i < NUM_LANES; i++) begin
        if (dest[i] == CNT_W'(k))
          slots_out[k*BYTE_W +: BYTE_W] = slots_out[k*BYTE_W +: BYTE_W]
                                        | bytes_in[i*BYTE_W +: BYTE_W];
      end
    end
  end
endmodule

// File: rtl/tc513_transcoder.sv
module tc513_transcoder
  import tc513_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_blocks,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_word,
  output logic             out_err
);
  logic [NUM_LANES-1:0] is_ctl;
  logic [NUM_LANES-1:0] bad_hdr;
  logic [NUM_LANES-1:0] ctl_above;
  logic [FB_W-1:0]      lead_bytes;
  logic [FB_W-1:0]      slots;
  logic [OUT_W-1:0]     word_nxt;

  genvar g;
  generate
    for (g = 0; g < NUM_LANES; g++) begin : g_lane
      if (g == NUM_LANES - 1) begin : g_top
        assign ctl_above[g] = 1'b0;
      end else begin : g_mid
        assign ctl_above[g] = |is_ctl[NUM_LANES-1:g+1];
      end

      tc513_lane_classify #(.LANE(g)) u_cls (
        .blk       (in_blocks[g*BLK_W +: BLK_W]),
        .ctl_above (ctl_above[g]),
        .is_ctl    (is_ctl[g]),
        .bad_hdr   (bad_hdr[g]),
        .lead_byte (lead_bytes[g*BYTE_W +: BYTE_W])
      );

      assign word_nxt[1 + FB_W + g*REST_W +: REST_W] =
        in_blocks[g*BLK_W + 2 + BYTE_W +: REST_W];
    end
  endgenerate

  tc513_byte_router u_route (
    .is_ctl    (is_ctl),
    .bytes_in  (lead_bytes),
    .slots_out (slots)
  );

  assign word_nxt[0]        = |is_ctl;
  assign word_nxt[FB_W:1]   = slots;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_err   <= 1'b0;
      out_word  <= '0;
    end else begin
      out_valid <= in_valid;
      out_err   <= in_valid & (|bad_hdr);
      if (in_valid) out_word <= word_nxt;
    end
  end
endmodule

// File: rtl/tc513_transcoder_chk.sv
module tc513_transcoder_chk
  import tc513_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [IN_W-1:0]  in_blocks,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_word,
  input logic             out_err
);
  logic [NUM_LANES-1:0] hdr_ctl;
  genvar g;
  generate
    for (g = 0; g < NUM_LANES; g++) begin : g_h
      assign hdr_ctl[g] = (in_blocks[g*BLK_W +: 2] == 2'b10);
      p_rest_fixed_r9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_word[1 + FB_W + g*REST_W +: REST_W]
                     == $past(in_blocks[g*BLK_W + 10 +: REST_W]));
    end
  endgenerate

  p_valid_rise_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_valid_fall_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_word));
  p_hdr_data_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && hdr_ctl == '0) |=> !out_word[0]);
  p_hdr_ctl_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && hdr_ctl != '0) |=> out_word[0]);
  p_err_valid_r10: assert property (@(posedge clk) disable iff (rst)
    out_err |-> out_valid);
  p_reset_r11: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_err));
endmodule

bind tc513_transcoder tc513_transcoder_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_blocks (in_blocks),
  .out_valid (out_valid),
  .out_word  (out_word),
  .out_err   (out_err)
);

// File: tb/tc513_transcoder_tb_top.sv
module tc513_transcoder_tb_top;
  localparam int L = 8;
  localparam int IW = 528;
  localparam int OW = 513;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [IW-1:0] in_blocks = '0;
  logic          out_valid;
  logic [OW-1:0] out_word;
  logic          out_err;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tc513_transcoder dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_blocks(in_blocks),
    .out_valid(out_valid), .out_word(out_word), .out_err(out_err)
  );

  function automatic logic [OW-1:0] ref_word(input logic [IW-1:0] b);
    logic [OW-1:0] w;
    int slot;
    int last_c;
    w = '0;
    last_c = -1;
    for (int i = 0; i < L; i++) if (b[66*i +: 2] == 2'b10) last_c = i;
    w[0] = (last_c >= 0);
    slot = 0;
    for (int i = 0; i < L; i++) begin
      if (b[66*i +: 2] == 2'b10) begin
        logic [7:0] cb;
        cb[2:0] = 3'(i);
        cb[3]   = (i == last_c);
        cb[7:4] = b[66*i + 6 +: 4];
        w[1 + 8*slot +: 8] = cb;
        slot++;
      end
    end
    for (int i = 0; i < L; i++) begin
      if (b[66*i +: 2] != 2'b10) begin
        w[1 + 8*slot +: 8] = b[66*i + 2 +: 8];
        slot++;
      end
    end
    for (int i = 0; i < L; i++) w[65 + 56*i +: 56] = b[66*i + 10 +: 56];
    return w;
  endfunction

  function automatic logic ref_err(input logic [IW-1:0] b);
    logic e = 1'b0;
    for (int i = 0; i < L; i++)
      if (b[66*i +: 2] == 2'b00 || b[66*i +: 2] == 2'b11) e = 1'b1;
    return e;
  endfunction

  task automatic check_bit(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic check_vec(input string req, input logic [OW-1:0] act,
                           input logic [OW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [IW-1:0] b);
    logic [OW-1:0] e;
    logic all_data;
    in_blocks = b;
    in_valid  = 1'b1;
    @(negedge clk);
    e = ref_word(b);
    all_data = !e[0];
    check_bit("R2 valid after one cycle", out_valid, 1'b1);
    check_bit("R3 header bit", out_word[0], e[0]);
    if (all_data)
      check_vec("R5 R1 R4 data first-byte order", {448'b0, out_word[64:1]}, {448'b0, e[64:1]});
    else
      check_vec("R6 R7 R8 control first-byte order", {448'b0, out_word[64:1]}, {448'b0, e[64:1]});
    check_vec("R9 fixed trailing bytes", {out_word[OW-1:65], 65'b0}, {e[OW-1:65], 65'b0});
    check_bit("R10 error flag", out_err, ref_err(b));
  endtask

  function automatic logic [IW-1:0] make_word(input logic [L*2-1:0] hdrs);
    logic [IW-1:0] b;
    for (int i = 0; i < L; i++) begin
      b[66*i +: 2]  = hdrs[2*i +: 2];
      b[66*i + 2 +: 32] = $urandom;
      b[66*i + 34 +: 32] = $urandom;
    end
    return b;
  endfunction

  initial begin
    #400000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [OW-1:0] held;
    void'($urandom(32'd2024));
    in_blocks = make_word({8{2'b10}});
    in_valid  = 1'b1;
    repeat (3) @(negedge clk);
    check_bit("R11 reset valid", out_valid, 1'b0);
    check_bit("R11 reset err", out_err, 1'b0);
    check_vec("R11 reset word", out_word, '0);
    rst = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);

    send(make_word({8{2'b01}}));                  // R5 all data
    send(make_word({8{2'b10}}));                  // R6 all control
    send(make_word({2'b10, {7{2'b01}}}));         // R8 only lane 7 control
    send(make_word({{7{2'b01}}, 2'b10}));         // only lane 0 control
    send(make_word({2'b01, 2'b10, 2'b00, 2'b01, 2'b10, 2'b01, 2'b11, 2'b10})); // R10 with R6
    send(make_word({2'b11, {7{2'b01}}}));         // R10 error, all data

    // R2 hold: valid low, inputs change, output stays
    held = out_word;
    in_valid = 1'b0;
    in_blocks = make_word({8{2'b10}});
    @(negedge clk);
    check_bit("R2 valid low", out_valid, 1'b0);
    check_vec("R2 word held", out_word, held);
    check_bit("R10 err low without valid", out_err, 1'b0);

    for (int n = 0; n < 300; n++) begin
      logic [15:0] h;
      for (int i = 0; i < L; i++) begin
        int r = $urandom_range(0, 9);
        h[2*i +: 2] = (r < 5) ? 2'b01 : (r < 9) ? 2'b10 : 2'($urandom);
      end
      send(make_word(h));
      if ((n % 37) == 0) begin
        in_valid = 1'b0;
        @(negedge clk);
        check_bit("R2 idle gap", out_valid, 1'b0);
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule